// File: doc/BRIEF.md
# Register Pointer Bank Address Mapper

This block sits between an 8-bit controller core and its register file. It holds one writable pointer byte and turns each register access from the core into a physical register-file location, given as a bank number and a byte offset. The high nibble of the pointer picks a 16-byte working group. A short-form operand is a 4-bit register number, and it is placed inside that group. The low nibble of the pointer picks a bank. When that nibble is nonzero, only the sixteen lowest register addresses are redirected into the expanded bank it names. Every other address stays in bank 0.

The pointer is part of the register address space, at a fixed address that works under any bank setting. The core reads and writes the pointer through the same access port it uses for every register. Only some banks exist. An access that is redirected to a bank that does not exist is flagged invalid: it reads as zero and its write is dropped. The register-file storage, instruction decoding and the stack are outside this block.

Top module: `rp_bank_mapper`

## Requirements
- R1: After reset the pointer holds 00h, so a read of address FDh returns 00h.
- R2: A write to address FDh loads all 8 bits of the pointer. The pointer keeps its value in any cycle without such a write.
- R3: A pointer write takes effect at the next clock edge. In the cycle of the write, the read data and the mapping still come from the old pointer value.
- R4: When `acc_short_i` is 1, the effective address is {pointer[7:4], acc_addr_i[3:0]}. When it is 0, the effective address is `acc_addr_i`.
- R5: An effective address of 10h or above always maps to bank 0, with offset equal to the effective address, whatever the bank field holds.
- R6: An effective address from 00h to 0Fh maps to bank 0 when the pointer's low nibble is 0h.
- R7: An effective address from 00h to 0Fh maps to the bank named by the pointer's low nibble, with offset equal to the effective address, when that bank is implemented. The implemented banks are 0h, 1h, 2h, 3h, Dh and Fh.
- R8: An access redirected to an unimplemented bank drives `phys_valid_o` to 0 and `acc_rdata_o` to 00h, and never asserts `rf_we_o`.
- R9: Address FDh reaches the pointer under every bank setting. It maps to bank 0 with `phys_valid_o` at 1, and it never asserts `rf_we_o`.
- R10: A valid access that does not hit the pointer returns `rf_rdata_i` on `acc_rdata_o`. In that case `rf_we_o` equals `acc_we_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_addr_i | input | 8 | Register address from the core |
| acc_short_i | input | 1 | 1: the low nibble of the address is a short-form working-register number |
| acc_we_i | input | 1 | Write strobe for this access |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Read data returned to the core |
| rf_rdata_i | input | 8 | Data read from the register file at the physical location |
| phys_bank_o | output | 4 | Physical bank number |
| phys_off_o | output | 8 | Physical byte offset within the bank |
| phys_valid_o | output | 1 | The physical location exists |
| rf_we_o | output | 1 | Write strobe to the register file |

## Verification
The bench goes after the boundary between offsets 0Fh and 10h. A design that compared the wrong nibble would send high addresses into expanded banks, or leave low ones in bank 0. It writes the pointer with bank values that are not implemented, such as Ah, and with short-form operands. A wrong implemented-bank decode would let a write land in a missing bank, or return stale data instead of zero. Back-to-back pointer writes and reads check that a mapping which updated too early would show the new value in the cycle of the write. They also check that the pointer stays at FDh under every bank setting.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = DATA_W / 2;
  localparam int unsigned NBANK  = 1 << NIB_W;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [NIB_W-1:0]  nib_t;

  typedef struct packed {
    nib_t  bank;
    byte_t off;
    logic  valid;
  } phys_t;
endpackage

// File: rtl/rp_reg.sv
module rp_reg
  import rp_pkg::*;
#(
  parameter byte_t RST_VAL = '0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  byte_t d_i,
  output byte_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/rp_addr_expand.sv
module rp_addr_expand
  import rp_pkg::*;
(
  input  logic  short_i,
  input  byte_t addr_i,
  input  nib_t  grp_i,
  output byte_t full_o
);
  // short operand lands inside the selected 16-byte working group
  always_comb begin
    if (short_i) full_o = {grp_i, addr_i[NIB_W-1:0]};
    else         full_o = addr_i;
  end
endmodule

// File: rtl/rp_bank_remap.sv
module rp_bank_remap
  import rp_pkg::*;
#(
  parameter logic [NBANK-1:0] IMPL_MASK = 16'hA00F
) (
  input  byte_t full_i,
  input  nib_t  bank_sel_i,
  output phys_t phys_o
);
  logic [NBANK-1:0] impl_vec;
  logic             low_region;
  nib_t             bank_eff;

  for (genvar b = 0; b < NBANK; b++) begin : g_impl
    if (b == 0) begin : g_base
      assign impl_vec[b] = 1'b1;  // base file always present
    end else begin : g_exp
      assign impl_vec[b] = IMPL_MASK[b];
    end
  end

  assign low_region = (full_i[DATA_W-1:NIB_W] == '0);
  assign bank_eff   = low_region ? bank_sel_i : '0;

  always_comb begin
    phys_o.bank  = bank_eff;
    phys_o.off   = full_i;
    phys_o.valid = impl_vec[bank_eff];
  end
endmodule

// File: rtl/rp_bank_mapper.sv
module rp_bank_mapper
  import rp_pkg::*;
#(
  parameter byte_t             RP_ADDR   = 8'hFD,
  parameter byte_t             RP_RST    = 8'h00,
  parameter logic [NBANK-1:0]  IMPL_MASK = 16'hA00F
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  acc_addr_i,
  input  logic        acc_short_i,
  input  logic        acc_we_i,
  input  logic [7:0]  acc_wdata_i,
  output logic [7:0]  acc_rdata_o,
  input  logic [7:0]  rf_rdata_i,
  output logic [3:0]  phys_bank_o,
  output logic [7:0]  phys_off_o,
  output logic        phys_valid_o,
  output logic        rf_we_o
);
  byte_t rp_q;
  byte_t full_addr;
  phys_t phys;
  logic  rp_hit;
  logic  rp_wr;

  rp_addr_expand u_expand (
    .short_i (acc_short_i),
    .addr_i  (acc_addr_i),
    .grp_i   (rp_q[DATA_W-1:NIB_W]),
    .full_o  (full_addr)
  );

  rp_bank_remap #(.IMPL_MASK(IMPL_MASK)) u_remap (
    .full_i     (full_addr),
    .bank_sel_i (rp_q[NIB_W-1:0]),
    .phys_o     (phys)
  );

  assign rp_hit = (full_addr == RP_ADDR);
  assign rp_wr  = acc_we_i & rp_hit;

  rp_reg #(.RST_VAL(RP_RST)) u_rp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (rp_wr),
    .d_i    (acc_wdata_i),
    .q_o    (rp_q)
  );

  assign phys_bank_o  = phys.bank;
  assign phys_off_o   = phys.off;
  assign phys_valid_o = phys.valid;
  assign rf_we_o      = acc_we_i & phys.valid & ~rp_hit;

  always_comb begin
    if (rp_hit)           acc_rdata_o = rp_q;
    else if (phys.valid)  acc_rdata_o = rf_rdata_i;
    else                  acc_rdata_o = '0;
  end
endmodule

// File: rtl/rp_bank_mapper_chk.sv
module rp_bank_mapper_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       acc_we_i,
  input logic [7:0] acc_wdata_i,
  input logic [7:0] acc_rdata_o,
  input logic [3:0] phys_bank_o,
  input logic [7:0] phys_off_o,
  input logic       phys_valid_o,
  input logic       rf_we_o,
  input logic [7:0] rp_q,
  input logic       rp_wr
);
  assert_rp_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rp_wr |=> rp_q == $past(acc_wdata_i));

  assert_rp_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rp_wr |=> $stable(rp_q));

  assert_high_bank0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phys_off_o >= 8'h10) |-> (phys_bank_o == 4'h0 && phys_valid_o));

  assert_low_bank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phys_off_o < 8'h10) |-> (phys_bank_o == rp_q[3:0]));

  assert_invalid_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phys_valid_o |-> (!rf_we_o && acc_rdata_o == 8'h00));

  assert_rp_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phys_off_o == 8'hFD) |-> (!rf_we_o && phys_valid_o && acc_rdata_o == rp_q));

  assert_we_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (acc_we_i && phys_valid_o));
endmodule

bind rp_bank_mapper rp_bank_mapper_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_we_i     (acc_we_i),
  .acc_wdata_i  (acc_wdata_i),
  .acc_rdata_o  (acc_rdata_o),
  .phys_bank_o  (phys_bank_o),
  .phys_off_o   (phys_off_o),
  .phys_valid_o (phys_valid_o),
  .rf_we_o      (rf_we_o),
  .rp_q         (rp_q),
  .rp_wr        (rp_wr)
);

// File: tb/rp_bank_mapper_test.sv
`timescale 1ns/1ps
module rp_bank_mapper_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] acc_addr_i = '0;
  logic       acc_short_i = 1'b0;
  logic       acc_we_i = 1'b0;
  logic [7:0] acc_wdata_i = '0;
  logic [7:0] acc_rdata_o;
  logic [7:0] rf_rdata_i = '0;
  logic [3:0] phys_bank_o;
  logic [7:0] phys_off_o;
  logic       phys_valid_o;
  logic       rf_we_o;

  int checks = 0;
  int fails = 0;
  logic [7:0] rp_m = 8'h00;
  bit done = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  rp_bank_mapper uut (.*);

  function automatic logic [7:0] eff_addr(logic [7:0] rp, logic [7:0] a, logic s);
    return s ? {rp[7:4], a[3:0]} : a;
  endfunction

  function automatic logic [3:0] exp_bank(logic [7:0] rp, logic [7:0] full);
    return (full[7:4] == 4'h0) ? rp[3:0] : 4'h0;
  endfunction

  function automatic logic bank_ok(logic [3:0] b);
    return b inside {4'h0, 4'h1, 4'h2, 4'h3, 4'hD, 4'hF};
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // one access: drive at negedge, compare mid-cycle, model update at edge
  task automatic access(string tag, logic [7:0] a, logic s, logic we,
                        logic [7:0] wd, logic [7:0] rfd);
    logic [7:0] full;
    logic [3:0] b;
    logic v, hit;
    logic [7:0] rd;
    @(negedge clk_i);
    acc_addr_i = a; acc_short_i = s; acc_we_i = we; acc_wdata_i = wd; rf_rdata_i = rfd;
    #2;
    full = eff_addr(rp_m, a, s);
    b    = exp_bank(rp_m, full);
    v    = bank_ok(b);
    hit  = (full == 8'hFD);
    rd   = hit ? rp_m : (v ? rfd : 8'h00);
    chk(tag, "bank",  {4'h0, phys_bank_o}, {4'h0, b});
    chk(tag, "off",   phys_off_o, full);
    chk(tag, "valid", {7'h0, phys_valid_o}, {7'h0, v});
    chk(tag, "rdata", acc_rdata_o, rd);
    chk(tag, "rf_we", {7'h0, rf_we_o}, {7'h0, we & v & ~hit});
    @(posedge clk_i);
    if (we && hit) rp_m = wd;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    access("R1", 8'hFD, 1'b0, 1'b0, 8'h00, 8'h77);
    // R3: write cycle still reports old pointer
    access("R3", 8'hFD, 1'b0, 1'b1, 8'h52, 8'h11);
    access("R2", 8'hFD, 1'b0, 1'b0, 8'h00, 8'h11);
    access("R4", 8'h07, 1'b1, 1'b0, 8'h00, 8'h3C);
    access("R7", 8'h0F, 1'b0, 1'b1, 8'h99, 8'hA5);
    access("R5", 8'h10, 1'b0, 1'b1, 8'h99, 8'hA6);
    access("R3", 8'hFD, 1'b0, 1'b1, 8'hCA, 8'h00);
    access("R8", 8'h05, 1'b0, 1'b1, 8'h44, 8'hEE);
    access("R9", 8'hFD, 1'b0, 1'b1, 8'hFD, 8'hEE);
    access("R4", 8'h0D, 1'b1, 1'b0, 8'h00, 8'h12);  // short hits FDh
    access("R9", 8'hFD, 1'b0, 1'b1, 8'h00, 8'h12);
    access("R6", 8'h0A, 1'b0, 1'b1, 8'h5A, 8'h5B);
    access("R10", 8'h80, 1'b0, 1'b0, 8'h00, 8'hC3);

    for (int i = 0; i < 600; i++) begin
      logic [7:0] a, wd;
      logic s, we;
      wd = 8'($urandom);
      if (($urandom % 4) == 0) begin
        a = 8'hFD; s = 1'b0; we = 1'b1;
      end else begin
        a  = (($urandom % 2) == 0) ? 8'($urandom % 16) : 8'($urandom);
        s  = (($urandom % 4) == 0);
        we = 1'($urandom);
      end
      access("R7/R8/R10 random", a, s, we, wd, 8'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule